// File: doc/BRIEF.md
# SD/MMC Command-Response Sequencer

This block sends one command to a memory card and collects the card's reply for a host controller. Software loads a 6-bit command index, a 32-bit argument written as two 16-bit halves, a block length and a block count through a small write port. It then writes a control word. The control word selects the reply class, says whether a data phase follows, and can hold the command back. The sequencer issues the command only while the card clock is enabled. Once the command has been taken, it collects the reply bytes from a byte-level card model.

When the reply ends, the block compares the number of bytes received against the minimum for the selected class. A reply that is long enough is packed into a nine-entry FIFO of 16-bit halfwords, which software reads one entry at a time. A reply that is too short is discarded and flagged as a timeout. Either outcome raises a sticky end-of-command interrupt request. A successful command with the data phase enabled keeps the transfer active and loads the data byte counter. Serial signalling and CRC are not part of this block.

The card side has two valid/ready streams. On the command stream, the block holds `cmd_valid`, `cmd_index` and `cmd_arg` steady until the card asserts `cmd_ready`. On the reply stream, the block raises `rsp_ready` only while it is collecting a reply. A byte is taken on each clock edge where `rsp_valid` and `rsp_ready` are both high. Collection ends on the byte flagged with `rsp_last`, or after `RSP_IDLE` consecutive cycles in which no byte arrives.

Top module: `sdcmd_seq`

## Requirements
- R1: Writing the control word (address 1) latches a pending command. The pending command is offered on the command stream only while the clock-enable status bit (bit 8) is set and control bit 10 (hold) is clear. A clock-port write (address 0) with bit 1 set enables the clock; a clock-port write with bit 0 set disables it and clears the transfer-active output.
- R2: Control bits [1:0] select the reply class. Class 0 expects no reply and collects no bytes. Classes 1 and 3 need at least 4 bytes. Class 2 needs at least 16 bytes.
- R3: If the reply is shorter than its class needs, the timeout status bit (bit 1) is set, bit 13 stays clear, the transfer becomes inactive, and all nine FIFO entries read zero.
- R4: On success, entry i holds reply byte 2i in bits [7:0] and byte 2i+1 in bits [15:8]. The response-done status bit (bit 13) is set, bit 1 is clear, and the read pointer returns to entry 0.
- R5: `rsp_word` shows the FIFO entry at the read pointer. A one-cycle `rsp_pop` pulse advances the pointer. After nine pops, `rsp_word` reads zero.
- R6: `cmd_echo` equals the 6-bit index ORed with 0x40.
- R7: A write to address 3 replaces only argument bits [31:16], and a write to address 4 replaces only bits [15:0]. The argument appears on `cmd_arg` with the command.
- R8: Every issued command sets `irq_end_cmd`, whether it succeeds or times out. A write to address 7 with bit 2 set clears it.
- R9: On success with control bit 2 (data enable) set, `xfer_active` stays high and `bytes_left` equals block count (address 6) × block length (address 5). Without data enable, or on timeout, `xfer_active` goes low.
- R10: The FIFO is cleared to zero when a command is dispatched, so entries beyond the received bytes read zero. Bytes after the 18th are dropped.
- R11: `cmd_valid`, `cmd_index` and `cmd_arg` hold steady until `cmd_ready`. Collection ends on `rsp_last` or after `RSP_IDLE` cycles with no byte. Status bits 1 and 13 are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| rsp_pop | input | 1 | Advance the reply FIFO read pointer |
| rsp_word | output | 16 | Reply FIFO entry at the read pointer |
| cmd_echo | output | 8 | Command index readback (index OR 0x40) |
| status | output | 16 | Bit 1 timeout, bit 8 clock enabled, bit 13 reply done |
| irq_end_cmd | output | 1 | Sticky end-of-command request |
| xfer_active | output | 1 | Transfer in progress |
| bytes_left | output | 28 | Data phase byte counter |
| cmd_valid | output | 1 | Command offered to the card |
| cmd_ready | input | 1 | Card takes the command |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Reply byte present |
| rsp_ready | output | 1 | Sequencer is collecting a reply |
| rsp_byte | input | 8 | Reply byte |
| rsp_last | input | 1 | Final reply byte |

## Verification
The bench probes the length thresholds one byte on each side: 3 and 4 bytes for the short classes, and 15 and 16 for the long class. A design with an off-by-one compare would report timeout on a valid reply, or success on a short one. A silent card relies on the idle counter alone; a design that waits only for `rsp_last` would hang there. Other tests hold a command back with the clock stopped or the hold bit set, and read past the ninth FIFO entry. These catch early dispatch, a FIFO that is not cleared after a timeout or a short reply, and a read pointer that wraps back to stale entries.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int RSP_ENTRIES = 9;
  localparam int RSP_BYTES   = 2 * RSP_ENTRIES;

  typedef enum logic [2:0] {
    A_CLK  = 3'd0,
    A_CTRL = 3'd1,
    A_IDX  = 3'd2,
    A_ARGH = 3'd3,
    A_ARGL = 3'd4,
    A_BLEN = 3'd5,
    A_NBLK = 3'd6,
    A_ICLR = 3'd7
  } cfg_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_COLLECT,
    ST_EVAL
  } seq_state_e;

  typedef struct packed {
    logic       hold;
    logic       data_en;
    logic [1:0] rclass;
  } ctrl_word_t;
endpackage

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
  import sdcmd_pkg::*;
#(
  parameter int BLEN_W = 12,
  parameter int NBLK_W = 16,
  localparam int BL_W = BLEN_W + NBLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              busy,
  input  logic              done_ok,
  input  logic              done_to,
  output logic              go,
  output ctrl_word_t        ctrl,
  output logic [5:0]        idx_q,
  output logic [31:0]       arg_q,
  output logic [15:0]       status,
  output logic              irq_q,
  output logic              active_q,
  output logic [BL_W-1:0]   bytes_left
);
  logic              pending_q, clk_en_q, to_q, done_q;
  logic [BLEN_W-1:0] blen_q;
  logic [NBLK_W-1:0] nblk_q;

  assign go     = pending_q && clk_en_q && !ctrl.hold && !busy;
  assign status = {2'b0, done_q, 4'b0, clk_en_q, 6'b0, to_q, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q  <= 1'b0;
      clk_en_q   <= 1'b0;
      to_q       <= 1'b0;
      done_q     <= 1'b0;
      irq_q      <= 1'b0;
      active_q   <= 1'b0;
      ctrl       <= '0;
      idx_q      <= '0;
      arg_q      <= '0;
      blen_q     <= '0;
      nblk_q     <= '0;
      bytes_left <= '0;
    end else begin
      if (go) begin
        pending_q <= 1'b0;
        active_q  <= 1'b1;
        to_q      <= 1'b0;
        done_q    <= 1'b0;
      end
      if (done_ok) begin
        done_q <= 1'b1;
        irq_q  <= 1'b1;
        if (ctrl.data_en) bytes_left <= BL_W'(nblk_q) * BL_W'(blen_q);
        else              active_q   <= 1'b0;
      end
      if (done_to) begin
        to_q     <= 1'b1;
        irq_q    <= 1'b1;
        active_q <= 1'b0;
      end
      if (cfg_we) begin
        unique case (cfg_addr_e'(cfg_addr))
          A_CLK: begin
            if (cfg_wdata[1]) clk_en_q <= 1'b1;
            if (cfg_wdata[0]) begin
              clk_en_q <= 1'b0;
              active_q <= 1'b0;
            end
          end
          A_CTRL: begin
            ctrl      <= {cfg_wdata[10], cfg_wdata[2], cfg_wdata[1:0]};
            pending_q <= 1'b1;
            active_q  <= 1'b0;
          end
          A_IDX:  idx_q         <= cfg_wdata[5:0];
          A_ARGH: arg_q[31:16]  <= cfg_wdata;
          A_ARGL: arg_q[15:0]   <= cfg_wdata;
          A_BLEN: blen_q        <= cfg_wdata[BLEN_W-1:0];
          A_NBLK: nblk_q        <= cfg_wdata[NBLK_W-1:0];
          A_ICLR: if (cfg_wdata[2] && !(done_ok || done_to)) irq_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdcmd_seq_fsm.sv
module sdcmd_seq_fsm
  import sdcmd_pkg::*;
#(
  parameter int RSP_IDLE = 16,
  localparam int IDLE_W = $clog2(RSP_IDLE + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [1:0] rclass,
  input  logic       cmd_ready,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_byte,
  input  logic       rsp_last,
  output logic       cmd_valid,
  output logic       rsp_ready,
  output logic       busy,
  output logic       fifo_clr,
  output logic       fifo_we,
  output logic [4:0] fifo_widx,
  output logic [7:0] fifo_wbyte,
  output logic       done_ok,
  output logic       done_to
);
  seq_state_e        state_q;
  logic [4:0]        cnt_q;
  logic [IDLE_W-1:0] idle_q;
  logic              long_enough;

  assign cmd_valid   = (state_q == ST_ISSUE);
  assign rsp_ready   = (state_q == ST_COLLECT);
  assign busy        = (state_q != ST_IDLE);
  assign long_enough = (rclass == 2'd0) ||
                       ((rclass == 2'd2) ? (cnt_q >= 5'd16) : (cnt_q >= 5'd4));
  assign done_ok     = (state_q == ST_EVAL) && long_enough;
  assign done_to     = (state_q == ST_EVAL) && !long_enough;
  assign fifo_clr    = go || done_to;
  assign fifo_we     = rsp_ready && rsp_valid && (cnt_q < 5'(RSP_BYTES));
  assign fifo_widx   = cnt_q;
  assign fifo_wbyte  = rsp_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idle_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_ISSUE;
          cnt_q   <= '0;
        end
        ST_ISSUE: if (cmd_ready) begin
          state_q <= (rclass == 2'd0) ? ST_EVAL : ST_COLLECT;
          idle_q  <= '0;
        end
        ST_COLLECT: begin
          if (rsp_valid) begin
            idle_q <= '0;
            if (cnt_q < 5'(RSP_BYTES)) cnt_q <= cnt_q + 5'd1;
            if (rsp_last) state_q <= ST_EVAL;
          end else if (idle_q == IDLE_W'(RSP_IDLE - 1)) begin
            state_q <= ST_EVAL;
          end else begin
            idle_q <= idle_q + 1'b1;
          end
        end
        ST_EVAL: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_rspfifo.sv
module sdcmd_rspfifo
  import sdcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        rewind,
  input  logic        we,
  input  logic [4:0]  widx,
  input  logic [7:0]  wbyte,
  input  logic        pop,
  output logic [15:0] head
);
  localparam int PTR_W = $clog2(RSP_ENTRIES + 1);

  logic [15:0]      ent_q [RSP_ENTRIES];
  logic [PTR_W-1:0] ptr_q;

  for (genvar e = 0; e < RSP_ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        ent_q[e] <= '0;
      end else if (we && (widx[4:1] == 4'(e))) begin
        if (widx[0]) ent_q[e][15:8] <= wbyte;
        else         ent_q[e][7:0]  <= wbyte;
      end
    end
  end

  assign head = (ptr_q < PTR_W'(RSP_ENTRIES)) ? ent_q[ptr_q[3:0]] : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || rewind) ptr_q <= '0;
    else if (pop && (ptr_q < PTR_W'(RSP_ENTRIES))) ptr_q <= ptr_q + 1'b1;
  end
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int BLEN_W   = 12,
  parameter int NBLK_W   = 16,
  parameter int RSP_IDLE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  input  logic        rsp_pop,
  output logic [15:0] rsp_word,
  output logic [7:0]  cmd_echo,
  output logic [15:0] status,
  output logic        irq_end_cmd,
  output logic        xfer_active,
  output logic [BLEN_W+NBLK_W-1:0] bytes_left,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [5:0]  cmd_index,
  output logic [31:0] cmd_arg,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [7:0]  rsp_byte,
  input  logic        rsp_last
);
  ctrl_word_t ctrl;
  logic       go, busy, done_ok, done_to;
  logic       f_clr, f_we;
  logic [4:0] f_idx;
  logic [7:0] f_byte;

  sdcmd_regs #(.BLEN_W(BLEN_W), .NBLK_W(NBLK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .done_ok(done_ok), .done_to(done_to),
    .go(go), .ctrl(ctrl), .idx_q(cmd_index), .arg_q(cmd_arg),
    .status(status), .irq_q(irq_end_cmd), .active_q(xfer_active),
    .bytes_left(bytes_left)
  );

  sdcmd_seq_fsm #(.RSP_IDLE(RSP_IDLE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .rclass(ctrl.rclass),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .rsp_last(rsp_last), .cmd_valid(cmd_valid), .rsp_ready(rsp_ready),
    .busy(busy), .fifo_clr(f_clr), .fifo_we(f_we), .fifo_widx(f_idx),
    .fifo_wbyte(f_byte), .done_ok(done_ok), .done_to(done_to)
  );

  sdcmd_rspfifo u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(f_clr), .rewind(done_ok), .we(f_we),
    .widx(f_idx), .wbyte(f_byte), .pop(rsp_pop), .head(rsp_word)
  );

  assign cmd_echo = {2'b01, cmd_index};
endmodule

// File: rtl/sdcmd_seq_chk.sv
module sdcmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cmd_echo,
  input logic [15:0] status,
  input logic        irq_end_cmd,
  input logic        xfer_active,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [5:0]  cmd_index,
  input logic [31:0] cmd_arg,
  input logic        rsp_ready
);
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_index) && $stable(cmd_arg));

  p_echo_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_echo[7:6] == 2'b01);

  p_excl_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[1] && status[13]));

  p_irq_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[13]) || $rose(status[1]) |-> irq_end_cmd);

  p_timeout_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> !xfer_active);

  p_dispatch_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(status[8]));

  p_one_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rsp_ready));
endmodule

bind sdcmd_seq sdcmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_echo(cmd_echo), .status(status),
  .irq_end_cmd(irq_end_cmd), .xfer_active(xfer_active), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
  .rsp_ready(rsp_ready)
);

// File: tb/sdcmd_seq_tb.sv
module sdcmd_seq_tb;
  localparam int RSP_IDLE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        rsp_pop = 1'b0;
  logic [15:0] rsp_word;
  logic [7:0]  cmd_echo;
  logic [15:0] status;
  logic        irq_end_cmd, xfer_active, cmd_valid, rsp_ready;
  logic [27:0] bytes_left;
  logic        cmd_ready = 1'b0;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_byte = '0;
  logic        rsp_last = 1'b0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [7:0] bytes [18];

  always #2 clk = ~clk;

  sdcmd_seq #(.RSP_IDLE(RSP_IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rsp_pop(rsp_pop), .rsp_word(rsp_word),
    .cmd_echo(cmd_echo), .status(status), .irq_end_cmd(irq_end_cmd),
    .xfer_active(xfer_active), .bytes_left(bytes_left), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
    .rsp_last(rsp_last)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic need_ok(input int rc, input int n);
    if (rc == 0) return 1'b1;
    if (rc == 2) return n >= 16;
    return n >= 4;
  endfunction

  function automatic logic [15:0] exp_entry(input int rc, input int n, input int e);
    logic [15:0] w = 16'h0;
    if (rc == 0 || !need_ok(rc, n)) return 16'h0;
    if (2 * e < n)     w[7:0]  = bytes[2 * e];
    if (2 * e + 1 < n) w[15:8] = bytes[2 * e + 1];
    return w;
  endfunction

  // Card side: take the command, send n bytes, and wait for the outcome.
  task automatic run_cmd(input int rc, input int n, input logic den,
                         input logic [5:0] idx, input logic [31:0] arg,
                         input logic [11:0] blen, input logic [15:0] nblk);
    int wait_n;
    logic ok;
    wr(3'd2, {10'd0, idx});
    chk("R6 echo", {24'd0, cmd_echo}, {24'd0, 2'b01, idx});
    wr(3'd3, arg[31:16]);
    wr(3'd4, arg[15:0]);
    wr(3'd5, {4'd0, blen});
    wr(3'd6, nblk);
    wr(3'd7, 16'h0004);
    chk("R8 irq cleared", {31'd0, irq_end_cmd}, 32'd0);
    wr(3'd1, {5'd0, 1'b0, 7'd0, den, rc[1:0]});
    wait_n = 0;
    while (!cmd_valid && wait_n < 50) begin @(negedge clk); wait_n++; end
    chk("R1 dispatch", {31'd0, cmd_valid}, 32'd1);
    chk("R7 arg", cmd_arg, arg);
    chk("R7 index", {26'd0, cmd_index}, {26'd0, idx});
    repeat ($urandom_range(0, 2)) @(negedge clk);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    if (rc != 0) begin
      for (int i = 0; i < n; i++) begin
        bytes[i] = 8'($urandom);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        rsp_valid = 1'b1; rsp_byte = bytes[i]; rsp_last = (i == n - 1);
        while (!rsp_ready) @(negedge clk);
        @(negedge clk);
        rsp_valid = 1'b0; rsp_last = 1'b0;
      end
    end
    wait_n = 0;
    while (!(status[13] || status[1]) && wait_n < 200) begin @(negedge clk); wait_n++; end
    ok = need_ok(rc, n);
    chk("R2 class outcome done", {31'd0, status[13]}, {31'd0, ok});
    chk("R3 timeout bit", {31'd0, status[1]}, {31'd0, !ok});
    chk("R8 irq set", {31'd0, irq_end_cmd}, 32'd1);
    chk("R9 active", {31'd0, xfer_active}, {31'd0, ok && den});
    if (ok && den) chk("R9 byte count", {4'd0, bytes_left}, 32'(blen) * 32'(nblk));
    for (int e = 0; e < 9; e++) begin
      chk(ok ? "R4 R10 entry" : "R3 cleared entry", {16'd0, rsp_word}, {16'd0, exp_entry(rc, n, e)});
      rsp_pop = 1'b1;
      @(negedge clk);
      rsp_pop = 1'b0;
    end
    chk("R5 past ninth", {16'd0, rsp_word}, 32'd0);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", {16'd0, status}, 32'd0);
    chk("R1 reset cmd_valid", {31'd0, cmd_valid}, 32'd0);
    chk("R5 reset word", {16'd0, rsp_word}, 32'd0);
    // R1: clock stopped, so the command waits
    wr(3'd1, 16'h0001);
    repeat (8) @(negedge clk);
    chk("R1 held while clock off", {31'd0, cmd_valid}, 32'd0);
    // R1: hold bit keeps it back even with the clock on
    wr(3'd1, 16'h0401);
    wr(3'd0, 16'h0002);
    repeat (8) @(negedge clk);
    chk("R1 clock enabled", {31'd0, status[8]}, 32'd1);
    chk("R1 held by bit 10", {31'd0, cmd_valid}, 32'd0);
    // R1: stop then start the clock
    wr(3'd0, 16'h0001);
    chk("R1 clock disabled", {31'd0, status[8]}, 32'd0);
    wr(3'd0, 16'h0002);
    // Directed thresholds (R2)
    run_cmd(1, 3, 1'b0, 6'd17, 32'hDEAD_BEEF, 12'd512, 16'd4);
    run_cmd(3, 4, 1'b1, 6'd41, 32'h1234_5678, 12'd512, 16'd3);
    run_cmd(2, 15, 1'b1, 6'd2, 32'h0, 12'd8, 16'd8);
    run_cmd(2, 16, 1'b1, 6'd9, 32'hFFFF_0000, 12'd4095, 16'd65535);
    run_cmd(1, 0, 1'b0, 6'd63, 32'h0000_FFFF, 12'd1, 16'd1);
    run_cmd(0, 0, 1'b1, 6'd0, 32'hA5A5_5A5A, 12'd16, 16'd2);
    run_cmd(1, 18, 1'b0, 6'd55, 32'h8000_0001, 12'd3, 16'd5);
    // Random mix
    for (int k = 0; k < 30; k++) begin
      run_cmd(int'($urandom_range(0, 3)), int'($urandom_range(0, 18)),
              1'($urandom), 6'($urandom), $urandom, 12'($urandom), 16'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule